// File: doc/BRIEF.md
# Oldest-First Wakeup and Select Queue

This block is the holding station between instruction dispatch and execution in an out-of-order core. Each of its S slots keeps one waiting instruction: the instruction's sequence tag and, for each of its two source operands, the tag of the producing instruction together with a ready flag. Execution units announce finished results by driving completion tags on a set of broadcast ports. Every slot compares these tags against its two sources, and a match marks that source ready.

Each cycle the queue looks at the slots whose two sources are both ready and grants up to N of them, choosing the oldest first. Sequence tags have a fixed width and wrap around, so age is judged by modular difference. Granted slots leave the queue at the next clock edge. Dispatch places at most one instruction per cycle into the lowest free slot. It reads the exported occupancy and full flag to decide when to stall.

Top module: `wakeup_select_queue`

## Requirements
- R1: After reset the queue is empty: `occupancy` is 0, `full` is 0 and no `issue_valid` bit is set.
- R2: A dispatch presented while `full` is 0 is stored, and `occupancy` rises by one after the clock edge. A dispatch presented while `full` is 1 is dropped: occupancy does not change, and that instruction never appears on an issue port.
- R3: A slot is eligible for issue only when both of its source ready flags are set. A slot with a source still pending is never granted.
- R4: A completion broadcast whose tag equals a pending source tag marks that source ready. A broadcast with no matching tag changes nothing. A slot woken by a broadcast in cycle t can be granted no earlier than cycle t+1, and it is granted in cycle t+1 if it is among the N oldest eligible slots.
- R5: A completion broadcast in the same cycle as a dispatch is matched against the incoming sources, so the wakeup is not lost.
- R6: At most N slots are granted per cycle. Valid issue ports are packed from port 0 upward, and port k carries an older tag than port k+1.
- R7: Age uses modular comparison on the TW-bit tag: tag a is older than tag b when (a - b) mod 2^TW has its top bit set. For example, with TW = 6, tag 62 is older than tag 1.
- R8: A granted slot is freed at the clock edge that ends its grant cycle. Occupancy then drops by the number of grants, and the same instruction is never granted twice.
- R9: `full` is 1 exactly when `occupancy` equals S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_tag | input | TW | Sequence tag of the dispatched instruction |
| disp_src_a_tag | input | TW | Producer tag of source A |
| disp_src_a_rdy | input | 1 | Source A value already available |
| disp_src_b_tag | input | TW | Producer tag of source B |
| disp_src_b_rdy | input | 1 | Source B value already available |
| wake_valid | input | NB | One valid bit per completion broadcast port |
| wake_tag | input | NB*TW | Completion tags, port p at bits p*TW upward |
| issue_valid | output | N | Grant valid per issue port |
| issue_tag | output | N*TW | Granted tags, port k at bits k*TW upward |
| occupancy | output | $clog2(S+1) | Number of occupied slots |
| full | output | 1 | All slots occupied |

## Verification
The hardest condition to reach from the ports is several eligible slots at once whose ages run against their slot order, including a tag wraparound. Only that shows the select truly ranks by age and not by slot index. The stimulus holds every dispatched instruction behind one shared, unfinished producer tag while entries are placed in scrambled age order. A single broadcast then releases them all together, and the bench watches the grant sequence cycle by cycle. The same holding method fills the queue completely, so a dispatch can be presented against `full`.

// File: rtl/wsq_pkg.sv
// Package: shared helpers for the wakeup/select queue.
// Assumes the live tags span less than half of the tag space,
// so a modular difference gives a correct age order.
package wsq_pkg;

    // True when tag a was issued before tag b in a w-bit wrapping sequence.
    function automatic logic tag_older(input logic [31:0] a, input logic [31:0] b,
                                       input int unsigned w);
        logic [31:0] diff;
        diff = a - b;
        return diff[w-1];
    endfunction

endpackage

// File: rtl/wsq_slot.sv
// One queue slot: holds a tag and two source operands, snoops the
// completion broadcasts and reports when both sources are ready.
// Assumes load and clear are never raised for the same slot in one cycle.
module wsq_slot #(
    parameter int TW = 6,
    parameter int NB = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TW-1:0]    ld_tag,
    input  logic [TW-1:0]    ld_a_tag,
    input  logic             ld_a_rdy,
    input  logic [TW-1:0]    ld_b_tag,
    input  logic             ld_b_rdy,
    input  logic [NB-1:0]    bc_valid,
    input  logic [NB*TW-1:0] bc_tag,
    input  logic             clear,
    output logic             valid,
    output logic [TW-1:0]    tag,
    output logic             eligible
);

    logic          a_rdy, b_rdy;
    logic [TW-1:0] a_tag, b_tag;
    logic          a_hit, b_hit, lda_hit, ldb_hit;

    // Compare one source tag against every broadcast port.
    function automatic logic snoop(input logic [TW-1:0] st,
                                   input logic [NB-1:0] bv,
                                   input logic [NB*TW-1:0] bt);
        logic hit;
        hit = 1'b0;
        for (int p = 0; p < NB; p++)
            if (bv[p] && bt[p*TW +: TW] == st) hit = 1'b1;
        return hit;
    endfunction

    // Tag match for stored and incoming sources.
    always_comb begin
        a_hit   = snoop(a_tag, bc_valid, bc_tag);
        b_hit   = snoop(b_tag, bc_valid, bc_tag);
        lda_hit = snoop(ld_a_tag, bc_valid, bc_tag);
        ldb_hit = snoop(ld_b_tag, bc_valid, bc_tag);
    end

    // Slot state: fill, free, and ready-flag wakeup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            tag   <= '0;
            a_rdy <= 1'b0;
            b_rdy <= 1'b0;
            a_tag <= '0;
            b_tag <= '0;
        end else if (load) begin
            valid <= 1'b1;
            tag   <= ld_tag;
            a_rdy <= ld_a_rdy | lda_hit;
            b_rdy <= ld_b_rdy | ldb_hit;
            a_tag <= (ld_a_rdy | lda_hit) ? '0 : ld_a_tag;
            b_tag <= (ld_b_rdy | ldb_hit) ? '0 : ld_b_tag;
        end else if (clear) begin
            valid <= 1'b0;
        end else if (valid) begin
            if (!a_rdy && a_hit) begin
                a_rdy <= 1'b1;
                a_tag <= '0;
            end
            if (!b_rdy && b_hit) begin
                b_rdy <= 1'b1;
                b_tag <= '0;
            end
        end
    end

    // Eligibility uses only registered flags, so a wake is seen one cycle later.
    assign eligible = valid & a_rdy & b_rdy;

    p_no_fill_and_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && clear));
    p_freed_after_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !valid);
    p_wake_sets_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !clear && !load && !a_rdy && a_hit) |=> a_rdy);
    p_grant_needs_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> (a_rdy && b_rdy));

endmodule

// File: rtl/wsq_alloc.sv
// Allocator: counts occupied slots and steers one dispatch into the
// lowest free slot. Assumes at most one dispatch per cycle.
module wsq_alloc #(
    parameter int S  = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [S-1:0]  slot_valid,
    output logic [S-1:0]  load,
    output logic [CW-1:0] count,
    output logic          is_full
);

    // Population count of occupied slots.
    always_comb begin
        count = '0;
        for (int i = 0; i < S; i++)
            count = count + CW'(slot_valid[i]);
    end

    assign is_full = &slot_valid;

    // Lowest free slot wins the dispatch.
    always_comb begin
        logic found;
        found = 1'b0;
        load  = '0;
        for (int i = 0; i < S; i++) begin
            if (req && !slot_valid[i] && !found) begin
                load[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end

    p_fill_free_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load & slot_valid) == '0);
    p_single_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load));
    p_full_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_full |-> load == '0);

endmodule

// File: rtl/wsq_select.sv
// Age-ordered select: picks up to N eligible slots, oldest tag first,
// placing them on grant ports 0..N-1 in age order.
// Assumes live tags span less than half the tag space.
module wsq_select #(
    parameter int S  = 8,
    parameter int N  = 2,
    parameter int TW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [S-1:0]    elig,
    input  logic [S*TW-1:0] tags,
    output logic [S-1:0]    granted,
    output logic [N-1:0]    gv,
    output logic [N*TW-1:0] gtag
);
    import wsq_pkg::*;

    // N rounds of oldest-eligible search, each excluding earlier winners.
    always_comb begin
        logic [S-1:0] taken;
        taken = '0;
        gv    = '0;
        gtag  = '0;
        for (int k = 0; k < N; k++) begin
            logic found;
            int   best;
            found = 1'b0;
            best  = 0;
            for (int i = 0; i < S; i++) begin
                if (elig[i] && !taken[i] &&
                    (!found || tag_older(32'(tags[i*TW +: TW]),
                                         32'(tags[best*TW +: TW]), TW))) begin
                    found = 1'b1;
                    best  = i;
                end
            end
            if (found) begin
                taken[best]       = 1'b1;
                gv[k]             = 1'b1;
                gtag[k*TW +: TW]  = tags[best*TW +: TW];
            end
        end
        granted = taken;
    end

    p_grant_only_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (granted & ~elig) == '0);
    p_grant_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(granted) == $countones(gv));

    for (genvar k = 0; k + 1 < N; k++) begin : g_order
        p_ports_packed_r6: assert property (@(posedge clk) disable iff (!rst_n)
            gv[k+1] |-> gv[k]);
        p_age_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
            gv[k+1] |-> tag_older(32'(gtag[k*TW +: TW]), 32'(gtag[(k+1)*TW +: TW]), TW));
    end

endmodule

// File: rtl/wakeup_select_queue.sv
// Top: S-slot wakeup and select queue. Broadcast tags wake pending
// sources; up to N oldest ready slots are granted per cycle and freed
// at the following edge. Assumes one dispatch per cycle and that
// dispatch honours the full flag.
module wakeup_select_queue #(
    parameter int S  = 8,
    parameter int N  = 2,
    parameter int NB = 2,
    parameter int TW = 6,
    localparam int CW = $clog2(S + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic [TW-1:0]    disp_tag,
    input  logic [TW-1:0]    disp_src_a_tag,
    input  logic             disp_src_a_rdy,
    input  logic [TW-1:0]    disp_src_b_tag,
    input  logic             disp_src_b_rdy,
    input  logic [NB-1:0]    wake_valid,
    input  logic [NB*TW-1:0] wake_tag,
    output logic [N-1:0]     issue_valid,
    output logic [N*TW-1:0]  issue_tag,
    output logic [CW-1:0]    occupancy,
    output logic             full
);

    logic [S-1:0]    slot_valid, slot_elig, slot_load, slot_grant;
    logic [S*TW-1:0] slot_tag;

    wsq_alloc #(.S(S), .CW(CW)) u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (disp_valid),
        .slot_valid (slot_valid),
        .load       (slot_load),
        .count      (occupancy),
        .is_full    (full)
    );

    for (genvar i = 0; i < S; i++) begin : g_slot
        wsq_slot #(.TW(TW), .NB(NB)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (slot_load[i]),
            .ld_tag   (disp_tag),
            .ld_a_tag (disp_src_a_tag),
            .ld_a_rdy (disp_src_a_rdy),
            .ld_b_tag (disp_src_b_tag),
            .ld_b_rdy (disp_src_b_rdy),
            .bc_valid (wake_valid),
            .bc_tag   (wake_tag),
            .clear    (slot_grant[i]),
            .valid    (slot_valid[i]),
            .tag      (slot_tag[i*TW +: TW]),
            .eligible (slot_elig[i])
        );
    end

    wsq_select #(.S(S), .N(N), .TW(TW)) u_select (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig    (slot_elig),
        .tags    (slot_tag),
        .granted (slot_grant),
        .gv      (issue_valid),
        .gtag    (issue_tag)
    );

    p_occupancy_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> 32'(occupancy) == 32'($past(occupancy))
            + 32'($past(disp_valid && !full)) - 32'($countones($past(issue_valid))));
    p_full_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        full == (32'(occupancy) == S));
    p_empty_no_issue_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == '0) |-> (issue_valid == '0));

endmodule

// File: tb/wakeup_select_queue_test.sv
module wakeup_select_queue_test;
    localparam int S = 8, N = 2, NB = 2, TW = 6;
    localparam int CW = $clog2(S + 1);
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic disp_valid = 1'b0, disp_src_a_rdy = 1'b0, disp_src_b_rdy = 1'b0;
    logic [TW-1:0] disp_tag = '0, disp_src_a_tag = '0, disp_src_b_tag = '0;
    logic [NB-1:0] wake_valid = '0;
    logic [NB*TW-1:0] wake_tag = '0;
    logic [N-1:0] issue_valid;
    logic [N*TW-1:0] issue_tag;
    logic [CW-1:0] occupancy;
    logic full;

    int n_checks = 0, n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wakeup_select_queue #(.S(S), .N(N), .NB(NB), .TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_tag(disp_tag),
        .disp_src_a_tag(disp_src_a_tag), .disp_src_a_rdy(disp_src_a_rdy),
        .disp_src_b_tag(disp_src_b_tag), .disp_src_b_rdy(disp_src_b_rdy),
        .wake_valid(wake_valid), .wake_tag(wake_tag), .issue_valid(issue_valid),
        .issue_tag(issue_tag), .occupancy(occupancy), .full(full));

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Check the issue ports: count of grants and their tags in port order.
    task automatic chk_issue(input string req, input int cnt, input int t0, input int t1);
        int expv;
        expv = (cnt == 0) ? 0 : (cnt == 1) ? 1 : 3;
        chk(req, "issue_valid", int'(issue_valid), expv);
        if (cnt >= 1) chk(req, "issue_tag0", int'(issue_tag[0 +: TW]), t0);
        if (cnt >= 2) chk(req, "issue_tag1", int'(issue_tag[TW +: TW]), t1);
    endtask

    task automatic set_disp(input int t, input int a, input bit ar, input int b, input bit br);
        disp_valid = 1'b1; disp_tag = TW'(t);
        disp_src_a_tag = TW'(a); disp_src_a_rdy = ar;
        disp_src_b_tag = TW'(b); disp_src_b_rdy = br;
    endtask

    task automatic set_wake(input int p, input int t);
        wake_valid[p] = 1'b1;
        wake_tag[p*TW +: TW] = TW'(t);
    endtask

    task automatic idle_inputs();
        disp_valid = 1'b0;
        wake_valid = '0;
    endtask

    task automatic t_reset();
        chk("R1", "occupancy", int'(occupancy), 0);
        chk("R1", "full", int'(full), 0);
        chk_issue("R1", 0, 0, 0);
    endtask

    task automatic t_simple();
        set_disp(5, 0, 1, 0, 1);
        step(); idle_inputs();
        chk("R2", "occupancy after dispatch", int'(occupancy), 1);
        chk_issue("R8", 1, 5, 0);
        step();
        chk("R8", "occupancy after grant", int'(occupancy), 0);
        chk_issue("R8", 0, 0, 0);
    endtask

    task automatic t_one_source();
        set_disp(10, 3, 0, 0, 1);
        step(); idle_inputs();
        chk_issue("R3", 0, 0, 0);
        set_wake(0, 7);
        step(); idle_inputs();
        chk_issue("R4 nonmatching", 0, 0, 0);
        set_wake(1, 3);
        chk_issue("R4 same cycle as wake", 0, 0, 0);
        step(); idle_inputs();
        chk_issue("R4 next cycle", 1, 10, 0);
        step();
        chk("R8", "occupancy", int'(occupancy), 0);
    endtask

    task automatic t_two_sources();
        set_disp(12, 20, 0, 21, 0);
        step(); idle_inputs();
        set_wake(0, 20);
        step(); idle_inputs();
        chk_issue("R3 one pending", 0, 0, 0);
        set_wake(0, 21);
        step(); idle_inputs();
        chk_issue("R4 both ready", 1, 12, 0);
        step();
    endtask

    task automatic t_wake_at_dispatch();
        set_disp(14, 30, 0, 0, 1);
        set_wake(1, 30);
        step(); idle_inputs();
        chk_issue("R5", 1, 14, 0);
        step();
        chk("R5", "occupancy", int'(occupancy), 0);
    endtask

    task automatic t_age_order();
        int order[4] = '{40, 38, 41, 39};
        foreach (order[j]) begin
            set_disp(order[j], 50, 0, 0, 1);
            step(); idle_inputs();
        end
        chk("R2", "occupancy after four", int'(occupancy), 4);
        chk_issue("R3 held", 0, 0, 0);
        set_wake(0, 50);
        step(); idle_inputs();
        chk_issue("R6 first pair", 2, 38, 39);
        step();
        chk_issue("R6 second pair", 2, 40, 41);
        step();
        chk_issue("R8 drained", 0, 0, 0);
        chk("R8", "occupancy drained", int'(occupancy), 0);
    endtask

    task automatic t_wrap();
        set_disp(1, 55, 0, 0, 1);
        step();
        set_disp(62, 55, 0, 0, 1);
        step(); idle_inputs();
        set_wake(1, 55);
        step(); idle_inputs();
        chk_issue("R7", 2, 62, 1);
        step();
    endtask

    task automatic t_full();
        for (int j = 0; j < S; j++) begin
            set_disp(j, 60, 0, 0, 1);
            step(); idle_inputs();
        end
        chk("R9", "occupancy full", int'(occupancy), S);
        chk("R9", "full", int'(full), 1);
        set_disp(9, 0, 1, 0, 1);
        step(); idle_inputs();
        chk("R2", "occupancy after dropped dispatch", int'(occupancy), S);
        chk_issue("R2 dropped not issued", 0, 0, 0);
        set_wake(0, 60);
        step(); idle_inputs();
        for (int j = 0; j < S; j += 2) begin
            chk("R8", "occupancy while draining", int'(occupancy), S - j);
            chk_issue("R6 drain", 2, j, j + 1);
            step();
        end
        chk("R9", "full after drain", int'(full), 0);
        chk_issue("R2 dropped never issued", 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_simple();
        t_one_source();
        t_two_sources();
        t_wake_at_dispatch();
        t_age_order();
        t_wrap();
        t_full();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule